// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Controller

This block is a byte-wide serial peripheral interface controller that can act either as the clock-generating master or as a clocked slave. A single mode bit selects the role. In master role it derives the serial clock from the system clock through a power-of-two divider chosen by a 3-bit rate field. It frames each byte with an active-low select line. It shifts data out and in at the same time, most significant bit first. In slave role the clock, select and data inputs pass through a two-stage synchronizer. Edges are then detected on the system clock, and the same shift path is reused.

Software reaches the block through a small four-register port: control, rate, data and status. A write to the data register starts a master transfer, or preloads the byte the slave will return. A sticky completion flag is cleared by reading the data register, and it raises the interrupt line when interrupts are enabled. Each master-driven pin has an output value and an output enable, so a push-pull or an open-drain driver can be chosen. A software-controlled general-purpose output pin is also provided.

The controller is one state machine. Its states are `ST_IDLE`, `ST_M_SETUP`, `ST_M_SHIFT`, `ST_M_HOLD` and `ST_S_ACTIVE`. The transitions are:
- `ST_IDLE` to `ST_M_SETUP` on a data write in master role.
- `ST_M_SETUP` to `ST_M_SHIFT` after one half bit period.
- `ST_M_SHIFT` to `ST_M_HOLD` on the sixteenth clock edge.
- `ST_M_HOLD` to `ST_IDLE` after one full bit period, which sets the completion flag.
- `ST_IDLE` to `ST_S_ACTIVE` when the synchronized select is low in slave role.
- `ST_S_ACTIVE` to `ST_IDLE` when select returns high, or when the role changes to master.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset, the control register reads 0, which means slave role and interrupts disabled. The rate register also reads 0. `irq`, `gp_o` and every output enable are 0.
- R2: The register address decodes as follows:
  - Address 0 is control. Bit 0 selects master role, bit 1 is clock polarity, bit 2 is clock phase, bit 3 is interrupt enable, bit 4 selects open-drain drive and bit 5 is the general-purpose pin level. It reads back as written, with bits 7:6 reading 0.
  - Address 1 is the rate register. Bits 2:0 are stored and the upper bits read 0.
  - Address 2 is data. A write loads the transmit byte and a read returns the last received byte.
  - Address 3 is status. Bit 0 is the completion flag and bit 1 is busy.
- R3: In master role one serial clock half period lasts 4<<rate system clocks. A full bit period therefore lasts 8<<rate, which gives divide-by-8 for code 0 up to divide-by-1024 for code 7.
- R4: The rate value is captured when a master transfer starts. A rate write during a transfer does not alter that transfer's half period.
- R5: A master transfer moves 8 bits MSB first in both directions and produces 16 clock edges. With phase 0, data is sampled on the leading edge (the edge away from the idle level) and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge. The received byte is readable at address 2.
- R6: In master role the serial clock rests at the polarity bit's level whenever no transfer is running.
- R7: In master role the select output goes low once the transfer starts, stays low through all 16 edges, and returns high exactly one bit period (8<<rate clocks) after the last clock edge.
- R8: In master role with push-pull drive, all output enables for clock, select and data-out are 1. With open-drain drive each of those pins has output value 0 and output enable equal to the inverse of the pin's logical level.
- R9: In slave role the clock, select and data-out enables are 0 and the drive-type bit has no effect. The slave data output is enabled only while selected.
- R10: In slave role the block samples `mosi_i` and shifts `miso_o` according to the phase and polarity bits, using inputs synchronized through two flip-flops. After 16 edges it stores the received byte and sets the completion flag.
- R11: The completion flag is sticky until a read of address 2. `irq` is high exactly when the flag is set and the interrupt enable is 1.
- R12: `gp_o` follows control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational on address) |
| irq | output | 1 | Interrupt request |
| gp_o | output | 1 | General-purpose output pin |
| sclk_i | input | 1 | Serial clock input (slave role) |
| sclk_o | output | 1 | Serial clock output value |
| sclk_oe | output | 1 | Serial clock output enable |
| sen_i | input | 1 | Active-low select input (slave role) |
| sen_o | output | 1 | Active-low select output value |
| sen_oe | output | 1 | Select output enable |
| mosi_i | input | 1 | Master-out data input (slave role) |
| mosi_o | output | 1 | Master-out data output value |
| mosi_oe | output | 1 | Master-out data output enable |
| miso_i | input | 1 | Master-in data input (master role) |
| miso_o | output | 1 | Slave-out data output value |
| miso_oe | output | 1 | Slave-out data output enable |

## Verification
The edge counter, the toggle register and the state register steer every pin. An edge counter that is off by one shows up within one transfer as a missing or extra clock edge, a shifted received byte, or a select that releases early. A corrupted captured rate shows up as a half period of the wrong length at the very next edge. A stale completion flag or interrupt enable shows on `irq` in the cycle after the data read or control write. A wrong state in slave role shows on `miso_oe` within three clocks of the select changing.

// File: rtl/spi_pkg.sv
package spi_pkg;

    // Control register layout; master lands on bit 0
    typedef struct packed {
        logic gp;
        logic od;
        logic ien;
        logic cpha;
        logic cpol;
        logic master;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_SETUP,
        ST_M_SHIFT,
        ST_M_HOLD,
        ST_S_ACTIVE
    } state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_RATE = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int RATE_W     = 3,
    parameter int BASE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = BASE_SHIFT + (1 << RATE_W);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_len;

    always_comb begin
        half_len = CNT_W'(1) << (BASE_SHIFT + int'(rate));
        tick     = run && (cnt_q == half_len - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++)
                stage_q[i] <= '1;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample,
    input  logic         shift,
    input  logic         din,
    output logic         dout,
    output logic [W-1:0] rx
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load)
                tx_q <= load_val;
            else if (shift)
                tx_q <= {tx_q[W-2:0], 1'b0};
            if (sample)
                rx_q <= {rx_q[W-2:0], din};
        end
    end

    assign dout = tx_q[W-1];
    assign rx   = rx_q;
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
    import spi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RATE_W      = 3,
    parameter int BASE_SHIFT  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              gp_o,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sen_i,
    output logic              sen_o,
    output logic              sen_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int EDGES  = 2 * DATA_W;
    localparam int ECNT_W = $clog2(EDGES + 1);

    ctrl_t              ctrl_q;
    logic [RATE_W-1:0]  rate_q, rate_lat;
    state_t             state_q, state_d;
    logic [ECNT_W-1:0]  ecnt_q;
    logic               hold_q, tgl_q, done_q, fin_q, s_sclk_prev;
    logic [DATA_W-1:0]  rxd_q, rx_sh;

    logic s_sclk, s_sen, s_mosi;
    logic wr_ctrl, wr_rate, wr_data, rd_data;
    logic m_busy, start_m, load_tx, tick;
    logic m_edge, s_edge, edge_any, lead, sample, shift, last_edge, hold_end;
    logic sclk_v, sen_v, mosi_v, done_set;

    // Input synchronizer for slave role
    spi_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, sen_i, mosi_i}),
        .q     ({s_sclk, s_sen, s_mosi})
    );

    // Half-period tick generator
    spi_clk_div #(.RATE_W(RATE_W), .BASE_SHIFT(BASE_SHIFT)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_busy),
        .rate  (rate_lat),
        .tick  (tick)
    );

    // Shared shift path
    spi_shift #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_tx),
        .load_val (reg_wdata),
        .sample   (sample),
        .shift    (shift),
        .din      (ctrl_q.master ? miso_i : s_mosi),
        .dout     (mosi_v),
        .rx       (rx_sh)
    );

    // Decode and edge classification
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
        wr_rate   = reg_wr && (reg_addr == A_RATE);
        wr_data   = reg_wr && (reg_addr == A_DATA);
        rd_data   = reg_rd && (reg_addr == A_DATA);
        m_busy    = (state_q == ST_M_SETUP) || (state_q == ST_M_SHIFT) || (state_q == ST_M_HOLD);
        start_m   = wr_data && ctrl_q.master && (state_q == ST_IDLE);
        load_tx   = wr_data && (state_q == ST_IDLE);
        m_edge    = (state_q == ST_M_SHIFT) && tick;
        s_edge    = (state_q == ST_S_ACTIVE) && (s_sclk != s_sclk_prev);
        edge_any  = (m_edge || s_edge) && (ecnt_q < ECNT_W'(EDGES));
        lead      = ctrl_q.master ? !ecnt_q[0] : (s_sclk != ctrl_q.cpol);
        sample    = edge_any && (lead ^ ctrl_q.cpha);
        shift     = edge_any && !(lead ^ ctrl_q.cpha) && (ecnt_q != '0);
        last_edge = edge_any && (ecnt_q == ECNT_W'(EDGES - 1));
        hold_end  = (state_q == ST_M_HOLD) && tick && hold_q;
        done_set  = hold_end || fin_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_m)
                    state_d = ST_M_SETUP;
                else if (!ctrl_q.master && !s_sen)
                    state_d = ST_S_ACTIVE;
            end
            ST_M_SETUP:  if (tick)      state_d = ST_M_SHIFT;
            ST_M_SHIFT:  if (last_edge) state_d = ST_M_HOLD;
            ST_M_HOLD:   if (hold_end)  state_d = ST_IDLE;
            ST_S_ACTIVE: if (s_sen || ctrl_q.master) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            rate_q      <= '0;
            rate_lat    <= '0;
            ecnt_q      <= '0;
            hold_q      <= 1'b0;
            tgl_q       <= 1'b0;
            fin_q       <= 1'b0;
            done_q      <= 1'b0;
            rxd_q       <= '0;
            s_sclk_prev <= 1'b1;
        end else begin
            s_sclk_prev <= s_sclk;
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_rate) rate_q <= reg_wdata[RATE_W-1:0];
            if (start_m) rate_lat <= rate_q;

            if (state_q == ST_IDLE)
                ecnt_q <= '0;
            else if (edge_any)
                ecnt_q <= ecnt_q + ECNT_W'(1);

            if (state_q == ST_IDLE)
                tgl_q <= 1'b0;
            else if (m_edge)
                tgl_q <= ~tgl_q;

            if (state_q != ST_M_HOLD)
                hold_q <= 1'b0;
            else if (tick)
                hold_q <= 1'b1;

            fin_q <= last_edge && (state_q == ST_S_ACTIVE);

            if (done_set) begin
                done_q <= 1'b1;
                rxd_q  <= rx_sh;
            end else if (rd_data) begin
                done_q <= 1'b0;
            end
        end
    end

    // Output logic
    always_comb begin
        sclk_v = ctrl_q.cpol ^ tgl_q;
        sen_v  = !m_busy;
        if (ctrl_q.master) begin
            if (ctrl_q.od) begin
                {sclk_o, sclk_oe} = {1'b0, ~sclk_v};
                {sen_o,  sen_oe}  = {1'b0, ~sen_v};
                {mosi_o, mosi_oe} = {1'b0, ~mosi_v};
            end else begin
                {sclk_o, sclk_oe} = {sclk_v, 1'b1};
                {sen_o,  sen_oe}  = {sen_v,  1'b1};
                {mosi_o, mosi_oe} = {mosi_v, 1'b1};
            end
            miso_o  = 1'b0;
            miso_oe = 1'b0;
        end else begin
            {sclk_o, sclk_oe} = 2'b00;
            {sen_o,  sen_oe}  = 2'b00;
            {mosi_o, mosi_oe} = 2'b00;
            miso_oe = (state_q == ST_S_ACTIVE);
            miso_o  = miso_oe && mosi_v;
        end
        irq  = done_q && ctrl_q.ien;
        gp_o = ctrl_q.gp;
        unique case (reg_addr)
            A_CTRL:  reg_rdata = DATA_W'(ctrl_q);
            A_RATE:  reg_rdata = DATA_W'(rate_q);
            A_DATA:  reg_rdata = rxd_q;
            default: reg_rdata = DATA_W'({(state_q != ST_IDLE), done_q});
        endcase
    end
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master,
    input logic              od,
    input logic              cpol,
    input logic              ien,
    input logic              busy_m,
    input logic              sclk_v,
    input logic              sclk_o,
    input logic              sen_o,
    input logic              mosi_o,
    input logic              sclk_oe,
    input logic              sen_oe,
    input logic              mosi_oe,
    input logic              irq,
    input logic [RATE_W-1:0] rate_lat
);
    // R4
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_m && $past(busy_m)) |-> $stable(rate_lat));

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !busy_m) |-> (sclk_v == cpol));

    // R7
    select_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !od && busy_m) |-> (sen_oe && !sen_o));

    // R8
    open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master && od) |-> (!sclk_o && !sen_o && !mosi_o));

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (!sclk_oe && !sen_oe && !mosi_oe));

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien);
endmodule

bind spi_ctl_top spi_ctl_chk #(.RATE_W(RATE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .master   (ctrl_q.master),
    .od       (ctrl_q.od),
    .cpol     (ctrl_q.cpol),
    .ien      (ctrl_q.ien),
    .busy_m   (m_busy),
    .sclk_v   (sclk_v),
    .sclk_o   (sclk_o),
    .sen_o    (sen_o),
    .mosi_o   (mosi_o),
    .sclk_oe  (sclk_oe),
    .sen_oe   (sen_oe),
    .mosi_oe  (mosi_oe),
    .irq      (irq),
    .rate_lat (rate_lat)
);

// File: tb/tb_spi_ctl_top.sv
module tb_spi_ctl_top;
    localparam int HP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic irq, gp_o;
    logic sclk_i = 1'b0, sen_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
    logic sclk_o, sclk_oe, sen_o, sen_oe, mosi_o, mosi_oe, miso_o, miso_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    spi_ctl_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .gp_o(gp_o),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .sen_i(sen_i), .sen_o(sen_o), .sen_oe(sen_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic line(input logic o, input logic oe);
        return oe ? o : 1'b1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] d;
        chk("R1 irq", irq, 0);
        chk("R1 gp_o", gp_o, 0);
        chk("R1 enables", {sclk_oe, sen_oe, mosi_oe, miso_oe}, 0);
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R1 rate", d, 8'h00);
    endtask

    task automatic test_regs();
        logic [7:0] d;
        wr(2'd0, 8'hEA);
        rd(2'd0, d); chk("R2 ctrl readback", d, 8'h2A);
        chk("R12 gp high", gp_o, 1);
        wr(2'd1, 8'hFD);
        rd(2'd1, d); chk("R2 rate readback", d, 8'h05);
        wr(2'd0, 8'h00);
        chk("R12 gp low", gp_o, 0);
    endtask

    task automatic master_xfer(input logic cpol, input logic cpha, input logic od,
                               input int rate, input logic [7:0] txb,
                               input logic [7:0] slvb, input bit mid_rate);
        logic [7:0] sh, got, d;
        logic prev, s;
        int edges, prev_t, bad_half, rise_t, guard;
        bit od_bad, pp_bad, sen_bad, pulse_on, pulsed;
        wr(2'd1, 8'(rate));
        wr(2'd0, {3'b000, od, 1'b1, cpha, cpol, 1'b1});
        @(negedge clk);
        chk("R6 idle clock level", line(sclk_o, sclk_oe), cpol);
        sh = slvb; miso_i = sh[7];
        wr(2'd2, txb);
        edges = 0; prev = cpol; bad_half = 0; got = 0; guard = 0;
        rise_t = -1; prev_t = cyc; od_bad = 0; pp_bad = 0; sen_bad = 0;
        pulse_on = 0; pulsed = 0;
        while (rise_t < 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (pulse_on) begin reg_wr = 1'b0; pulse_on = 0; end
            if (mid_rate && !pulsed && edges == 2) begin
                reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'd3;
                pulse_on = 1; pulsed = 1;
            end
            if (od && (sclk_o || sen_o || mosi_o)) od_bad = 1;
            if (!od && !(sclk_oe && sen_oe && mosi_oe)) pp_bad = 1;
            if (edges < 16 && line(sen_o, sen_oe) !== 1'b0) sen_bad = 1;
            s = line(sclk_o, sclk_oe);
            if (s !== prev) begin
                if (edges > 0 && (cyc - prev_t) != (4 << rate)) bad_half++;
                prev_t = cyc; prev = s;
                if ((s !== cpol) ^ cpha)
                    got = {got[6:0], line(mosi_o, mosi_oe)};
                else if (edges != 0) begin
                    sh = sh << 1; miso_i = sh[7];
                end
                edges++;
            end
            if (edges == 16 && line(sen_o, sen_oe) === 1'b1) rise_t = cyc;
        end
        chk(mid_rate ? "R4 half period kept" : "R3 half period", bad_half, 0);
        chk("R5 edge count", edges, 16);
        chk("R5 master sent byte", got, txb);
        chk("R7 select held low", sen_bad, 0);
        chk("R7 select release delay", rise_t - prev_t, 8 << rate);
        chk(od ? "R8 open-drain values" : "R8 push-pull enables", od ? od_bad : pp_bad, 0);
        rd(2'd3, d); chk("R11 done set", d, 8'h01);
        chk("R11 irq on", irq, 1);
        rd(2'd2, d); chk("R5 master received byte", d, slvb);
        chk("R11 irq cleared", irq, 0);
        rd(2'd3, d); chk("R11 done cleared", d, 8'h00);
    endtask

    task automatic slave_xfer(input logic cpol, input logic cpha,
                              input logic [7:0] txb, input logic [7:0] mstb);
        logic [7:0] got, d;
        sclk_i = cpol; sen_i = 1'b1; mosi_i = 1'b0;
        wr(2'd0, {3'b000, 1'b1, 1'b0, cpha, cpol, 1'b0});
        wr(2'd2, txb);
        @(negedge clk);
        chk("R9 slave pins released", {sclk_oe, sen_oe, mosi_oe, miso_oe}, 0);
        sen_i = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 slave out enabled", miso_oe, 1);
        got = 0;
        for (int i = 7; i >= 0; i--) begin
            if (!cpha) begin
                mosi_i = mstb[i];
                repeat (HP) @(negedge clk);
                got = {got[6:0], miso_o};
                sclk_i = ~cpol;
                repeat (HP) @(negedge clk);
                sclk_i = cpol;
            end else begin
                sclk_i = ~cpol;
                mosi_i = mstb[i];
                repeat (HP) @(negedge clk);
                got = {got[6:0], miso_o};
                sclk_i = cpol;
                repeat (HP) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        rd(2'd3, d); chk("R10 slave done while selected", d, 8'h03);
        sen_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 irq gated off", irq, 0);
        chk("R9 slave out released", miso_oe, 0);
        chk("R10 slave sent byte", got, txb);
        rd(2'd2, d); chk("R10 slave received byte", d, mstb);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regs();
        master_xfer(1'b0, 1'b0, 1'b0, 0, 8'hA5, 8'h3C, 1'b0);
        master_xfer(1'b1, 1'b1, 1'b1, 1, 8'h81, 8'h7E, 1'b0);
        master_xfer(1'b0, 1'b1, 1'b0, 2, 8'h5A, 8'hC3, 1'b1);
        master_xfer(1'b1, 1'b0, 1'b0, 7, 8'h01, 8'h80, 1'b0);
        slave_xfer(1'b0, 1'b0, 8'h96, 8'h69);
        slave_xfer(1'b1, 1'b1, 8'hF0, 8'h0F);
        slave_xfer(1'b0, 1'b1, 8'h33, 8'hCC);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule